// File: doc/BRIEF.md
# Memory Window Bridge for a Register Bus

This block gives software access to an external synchronous SRAM through a window of a memory-mapped register bus. Every 32-bit RAM word shows up as one register-sized slot of 4 bytes, so a window of `DEPTH` words spans `4*DEPTH` bytes starting at `BASE`. The bridge keeps no copy of the data. It turns each bus request that falls inside the window into a memory cycle on a word address, write data and byte write enable port. For reads, it collects the RAM's answer one cycle after the RAM receives the address.

The bus side is a reduced register-bus slave. A single ready signal accepts either one write (address, data, byte strobes) or one read (address), and only one transaction is in flight at a time. Each transaction finishes with a one-cycle done pulse and a 2-bit response code. The `MODE` parameter fixes the access rights of the window:
- read-write,
- write-only, where reads return zero,
- read-only, where writes are acknowledged but never reach the RAM.

Top module: `memwin_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, `wr_done` and `rd_done` are 0 and `mem_wen` is 0.
- R2: A byte address `a` with `BASE <= a < BASE + 4*DEPTH` is inside the window and selects RAM word `(a - BASE) >> 2`. The first word is at `BASE` and the last at `BASE + 4*(DEPTH-1)`.
- R3: A write accepted on a clock edge drives `mem_addr`, `mem_wdata` and `mem_wen` in the cycle after that edge, for exactly one cycle. `wr_done` pulses in that same cycle, with `wr_resp` = 2'b00 (OKAY) when the address is in the window.
- R4: Bit i of `mem_wen` is bit i of the write strobe and enables RAM byte i (data bits 8i+7..8i). Bytes whose strobe is 0 keep their old value.
- R5: A read accepted on edge E0 puts the word address on `mem_addr` after E0 and samples `mem_rdata` on edge E0+2. `rd_done` is 1 only in the cycle after E0+2, with `rd_data` equal to the RAM word and `rd_resp` = 2'b00.
- R6: With `MODE` = write-only, in-window writes reach the RAM as in R3/R4, and reads finish with the R5 timing, `rd_data` = 0 and `rd_resp` = 2'b00.
- R7: With `MODE` = read-only, `mem_wen` stays 0 and RAM contents never change. Writes still finish with `wr_done` and `wr_resp` = 2'b00, and reads work as in R5.
- R8: A request outside the window gets `rd_resp`/`wr_resp` = 2'b11 (decode error) with the same timing as an in-window request. A write drives `mem_wen` = 0, and a read returns `rd_data` = 0.
- R9: `req_ready` is 0 from the acceptance edge until the done pulse has ended. When `wr_req` and `rd_req` are both high on an accepting edge, only the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request valid |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Write byte strobes |
| rd_req | input | 1 | Read request valid |
| rd_addr | input | ADDR_W | Read byte address |
| req_ready | output | 1 | Bridge idle, request accepted on this edge |
| wr_done | output | 1 | One-cycle write completion |
| wr_resp | output | 2 | Write response code (00 OKAY, 11 decode error) |
| rd_done | output | 1 | One-cycle read completion |
| rd_resp | output | 2 | Read response code (00 OKAY, 11 decode error) |
| rd_data | output | 32 | Read data, valid with `rd_done` |
| mem_addr | output | IDX_W | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_wen | output | 4 | RAM byte write enables |
| mem_rdata | input | 32 | RAM read data, one cycle after address |

## Verification
A write is due one cycle after its acceptance edge, when the memory port and `wr_done` appear together. A read result is due two edges after acceptance, with `rd_done` low in the two cycles before it. The bench drives every request on a falling edge and samples each of these cycles on the following falling edges, counted from the acceptance edge. It also checks that the done signal is low in the cycles where it must stay quiet. Three copies of the bridge, one per access mode, each with its own RAM model, see identical stimulus, and a bench-side word array predicts each mode's contents.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    typedef enum logic [1:0] {
        MODE_RW = 2'd0,
        MODE_WO = 2'd1,
        MODE_RO = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_DECERR = 2'b11
    } rsp_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WACK = 3'd1,
        ST_RD1  = 3'd2,
        ST_RD2  = 3'd3,
        ST_RACK = 3'd4
    } state_e;

    // Byte enables that may reach the RAM for a given mode and decode result
    function automatic logic [STRB_W-1:0] gate_wen(mode_e m, logic hit, logic [STRB_W-1:0] strb);
        return (hit && m != MODE_RO) ? strb : '0;
    endfunction

    function automatic logic read_allowed(mode_e m, logic hit);
        return hit && (m != MODE_WO);
    endfunction

endpackage

// File: rtl/memwin_decode.sv
module memwin_decode #(
    parameter int                ADDR_W = 16,
    parameter int                DEPTH  = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0100,
    localparam int               IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(4 * DEPTH);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off = addr - BASE;
        hit = (addr >= BASE) && ({1'b0, off} < SPAN);
        idx = off[IDX_W+1:2];
    end
endmodule

// File: rtl/memwin_ctrl.sv
module memwin_ctrl
    import memwin_pkg::*;
#(
    parameter int    IDX_W = 4,
    parameter mode_e MODE  = MODE_RW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              wr_hit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic              rd_req,
    input  logic              rd_hit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              req_ready,
    output logic              wr_done,
    output logic [1:0]        wr_resp,
    output logic              rd_done,
    output logic [1:0]        rd_resp,
    output logic              cap_en,
    output logic              rd_keep,
    output logic [IDX_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [STRB_W-1:0] mem_wen
);
    state_e state;
    rsp_e   wr_rsp_q, rd_rsp_q;
    logic   rd_hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_wen   <= '0;
            wr_rsp_q  <= RSP_OKAY;
            rd_rsp_q  <= RSP_OKAY;
            rd_hit_q  <= 1'b0;
        end else begin
            mem_wen <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (wr_req) begin
                        mem_addr  <= wr_idx;
                        mem_wdata <= wr_data;
                        mem_wen   <= gate_wen(MODE, wr_hit, wr_strb);
                        wr_rsp_q  <= wr_hit ? RSP_OKAY : RSP_DECERR;
                        state     <= ST_WACK;
                    end else if (rd_req) begin
                        mem_addr  <= rd_idx;
                        rd_hit_q  <= rd_hit;
                        rd_rsp_q  <= rd_hit ? RSP_OKAY : RSP_DECERR;
                        state     <= ST_RD1;
                    end
                end
                ST_WACK: state <= ST_IDLE;
                ST_RD1:  state <= ST_RD2;
                ST_RD2:  state <= ST_RACK;
                ST_RACK: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        wr_done   = (state == ST_WACK);
        rd_done   = (state == ST_RACK);
        wr_resp   = wr_rsp_q;
        rd_resp   = rd_rsp_q;
        cap_en    = (state == ST_RD2);
        rd_keep   = read_allowed(MODE, rd_hit_q);
    end

    // R3: byte enables last a single cycle
    a_r3_wen_single: assert property (@(posedge clk) disable iff (rst)
        (|mem_wen) |=> (mem_wen == '0));
    // R3: RAM write coincides with the write completion
    a_r3_wen_with_done: assert property (@(posedge clk) disable iff (rst)
        (|mem_wen) |-> wr_done);
    // R9: no new acceptance while a completion is shown
    a_r9_busy_on_done: assert property (@(posedge clk) disable iff (rst)
        (wr_done || rd_done) |-> !req_ready);
endmodule

// File: rtl/memwin_rcap.sv
module memwin_rcap
    import memwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              keep,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (cap_en)
            rd_data <= keep ? mem_rdata : '0;
    end
endmodule

// File: rtl/memwin_bridge.sv
module memwin_bridge
    import memwin_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter int                DEPTH  = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0100,
    parameter mode_e             MODE   = MODE_RW,
    localparam int               IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_strb,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              req_ready,
    output logic              wr_done,
    output logic [1:0]        wr_resp,
    output logic              rd_done,
    output logic [1:0]        rd_resp,
    output logic [31:0]       rd_data,
    output logic [IDX_W-1:0]  mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wen,
    input  logic [31:0]       mem_rdata
);
    logic             wr_hit, rd_hit, cap_en, rd_keep;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    memwin_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BASE(BASE)) u_wdec (
        .addr(wr_addr), .hit(wr_hit), .idx(wr_idx)
    );

    memwin_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BASE(BASE)) u_rdec (
        .addr(rd_addr), .hit(rd_hit), .idx(rd_idx)
    );

    memwin_ctrl #(.IDX_W(IDX_W), .MODE(MODE)) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_hit(wr_hit), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_req(rd_req), .rd_hit(rd_hit), .rd_idx(rd_idx),
        .req_ready(req_ready), .wr_done(wr_done), .wr_resp(wr_resp),
        .rd_done(rd_done), .rd_resp(rd_resp),
        .cap_en(cap_en), .rd_keep(rd_keep),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wen(mem_wen)
    );

    memwin_rcap u_rcap (
        .clk(clk), .rst(rst), .cap_en(cap_en), .keep(rd_keep),
        .mem_rdata(mem_rdata), .rd_data(rd_data)
    );

    // R5: read completion two cycles after the address cycle
    a_r5_read_latency: assert property (@(posedge clk) disable iff (rst)
        (req_ready && rd_req && !wr_req) |=> !rd_done ##1 !rd_done ##1 rd_done);
    // R9: accepted request takes the bridge out of idle
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_ready && (rd_req || wr_req)) |=> !req_ready);
    // R7: read-only window never enables a RAM byte
    a_r7_ro_no_wen: assert property (@(posedge clk) disable iff (rst)
        (MODE == MODE_RO && wr_done) |-> (mem_wen == '0));
    // R8: decode error writes never touch the RAM
    a_r8_decerr_no_wen: assert property (@(posedge clk) disable iff (rst)
        (wr_done && wr_resp == RSP_DECERR) |-> (mem_wen == '0));
    // R6: write-only window reads back zero
    a_r6_wo_zero: assert property (@(posedge clk) disable iff (rst)
        (MODE == MODE_WO && rd_done) |-> (rd_data == '0));
endmodule

// File: tb/sim_memwin_bridge.sv
`timescale 1ns/1ps

module sim_sram #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] addr,
    input  logic [31:0]      wdata,
    input  logic [3:0]       wen,
    output logic [31:0]      rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= 32'hA500_0000 | 32'(k);
            rdata <= '0;
        end else begin
            rdata <= mem[addr];
            for (int b = 0; b < 4; b++)
                if (wen[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
        end
    end
endmodule

module sim_memwin_bridge;
    import memwin_pkg::*;

    localparam int              ADDR_W = 16;
    localparam int              DEPTH  = 16;
    localparam int              IDX_W  = 4;
    localparam logic [15:0]     BASE   = 16'h0100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              wr_req = 0, rd_req = 0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [3:0]        wr_strb = '0;

    logic              req_ready [3];
    logic              wr_done   [3];
    logic [1:0]        wr_resp   [3];
    logic              rd_done   [3];
    logic [1:0]        rd_resp   [3];
    logic [31:0]       rd_data   [3];
    logic [IDX_W-1:0]  mem_addr  [3];
    logic [31:0]       mem_wdata [3];
    logic [3:0]        mem_wen   [3];
    logic [31:0]       mem_rdata [3];

    memwin_bridge #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BASE(BASE), .MODE(MODE_RW)) u0 (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb), .rd_req(rd_req), .rd_addr(rd_addr), .req_ready(req_ready[0]),
        .wr_done(wr_done[0]), .wr_resp(wr_resp[0]), .rd_done(rd_done[0]), .rd_resp(rd_resp[0]),
        .rd_data(rd_data[0]), .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]),
        .mem_wen(mem_wen[0]), .mem_rdata(mem_rdata[0]));
    memwin_bridge #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BASE(BASE), .MODE(MODE_WO)) u1 (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb), .rd_req(rd_req), .rd_addr(rd_addr), .req_ready(req_ready[1]),
        .wr_done(wr_done[1]), .wr_resp(wr_resp[1]), .rd_done(rd_done[1]), .rd_resp(rd_resp[1]),
        .rd_data(rd_data[1]), .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]),
        .mem_wen(mem_wen[1]), .mem_rdata(mem_rdata[1]));
    memwin_bridge #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BASE(BASE), .MODE(MODE_RO)) u2 (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb), .rd_req(rd_req), .rd_addr(rd_addr), .req_ready(req_ready[2]),
        .wr_done(wr_done[2]), .wr_resp(wr_resp[2]), .rd_done(rd_done[2]), .rd_resp(rd_resp[2]),
        .rd_data(rd_data[2]), .mem_addr(mem_addr[2]), .mem_wdata(mem_wdata[2]),
        .mem_wen(mem_wen[2]), .mem_rdata(mem_rdata[2]));

    for (genvar g = 0; g < 3; g++) begin : g_ram
        sim_sram #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
            .clk(clk), .rst(rst), .addr(mem_addr[g]), .wdata(mem_wdata[g]),
            .wen(mem_wen[g]), .rdata(mem_rdata[g]));
    end

    int n_cmp = 0, n_bad = 0;
    logic [31:0] model [3][DEPTH];

    task automatic chk(input bit ok, input string req, input int m,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s mode%0d actual=%h expected=%h", req, m, act, exp);
        end
    endtask

    function automatic bit in_win(logic [15:0] a);
        return a >= BASE && a < BASE + 16'(4 * DEPTH);
    endfunction

    // Starts and ends on a falling edge with the bridges idle
    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s,
                            input string req);
        bit h = in_win(a);
        logic [3:0] ix = 4'((a - BASE) >> 2);
        wr_req = 1; wr_addr = a; wr_data = d; wr_strb = s;
        @(negedge clk);
        wr_req = 0;
        for (int m = 0; m < 3; m++) begin
            logic [3:0] ew = (h && m != 2) ? s : 4'h0;
            chk(wr_done[m] == 1'b1, req, m, 32'(wr_done[m]), 32'd1);
            chk(wr_resp[m] == (h ? 2'b00 : 2'b11), req, m, 32'(wr_resp[m]), h ? 32'd0 : 32'd3);
            chk(mem_wen[m] == ew, "R4", m, 32'(mem_wen[m]), 32'(ew));
            chk(req_ready[m] == 1'b0, "R9", m, 32'(req_ready[m]), 32'd0);
            if (h) begin
                chk(mem_addr[m] == ix, "R2", m, 32'(mem_addr[m]), 32'(ix));
                chk(mem_wdata[m] == d, "R3", m, mem_wdata[m], d);
                for (int b = 0; b < 4; b++)
                    if (ew[b]) model[m][ix][8*b +: 8] = d[8*b +: 8];
            end
        end
        @(negedge clk);
        for (int m = 0; m < 3; m++)
            chk(mem_wen[m] == 4'h0 && wr_done[m] == 1'b0, "R3", m, 32'(mem_wen[m]), 32'd0);
    endtask

    task automatic do_read(input logic [15:0] a, input string req);
        bit h = in_win(a);
        logic [3:0] ix = 4'((a - BASE) >> 2);
        rd_req = 1; rd_addr = a;
        @(negedge clk);
        rd_req = 0;
        for (int m = 0; m < 3; m++) begin
            chk(rd_done[m] == 1'b0, "R5", m, 32'(rd_done[m]), 32'd0);
            chk(req_ready[m] == 1'b0, "R9", m, 32'(req_ready[m]), 32'd0);
            if (h) chk(mem_addr[m] == ix, "R2", m, 32'(mem_addr[m]), 32'(ix));
        end
        @(negedge clk);
        for (int m = 0; m < 3; m++)
            chk(rd_done[m] == 1'b0, "R5", m, 32'(rd_done[m]), 32'd0);
        @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            logic [31:0] ed = (!h || m == 1) ? 32'h0 : model[m][ix];
            chk(rd_done[m] == 1'b1, "R5", m, 32'(rd_done[m]), 32'd1);
            chk(rd_data[m] == ed, req, m, rd_data[m], ed);
            chk(rd_resp[m] == (h ? 2'b00 : 2'b11), req, m, 32'(rd_resp[m]), h ? 32'd0 : 32'd3);
        end
        @(negedge clk);
        for (int m = 0; m < 3; m++)
            chk(rd_done[m] == 1'b0 && req_ready[m] == 1'b1, "R9", m, 32'(rd_done[m]), 32'd0);
    endtask

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int m = 0; m < 3; m++)
            for (int k = 0; k < DEPTH; k++) model[m][k] = 32'hA500_0000 | 32'(k);
        repeat (3) @(negedge clk);
        rst = 0;
        for (int m = 0; m < 3; m++) begin
            chk(req_ready[m] == 1'b1, "R1", m, 32'(req_ready[m]), 32'd1);
            chk(wr_done[m] == 1'b0 && rd_done[m] == 1'b0, "R1", m, 32'(wr_done[m]), 32'd0);
            chk(mem_wen[m] == 4'h0, "R1", m, 32'(mem_wen[m]), 32'd0);
        end
        // initial contents visible (R7 read path, R6 zero read)
        for (int k = 0; k < DEPTH; k++) do_read(BASE + 16'(4 * k), "R6");
        // full-word sweep
        for (int k = 0; k < DEPTH; k++)
            do_write(BASE + 16'(4 * k), 32'h1000_0000 + 32'(k) * 32'h0101_0101, 4'hF, "R3");
        for (int k = 0; k < DEPTH; k++) do_read(BASE + 16'(4 * k), "R5");
        // every strobe pattern
        for (int s = 0; s < 16; s++) begin
            do_write(BASE + 16'(4 * (s % DEPTH)), ~(32'(s) * 32'h1111_1111), 4'(s), "R4");
            do_read(BASE + 16'(4 * (s % DEPTH)), "R4");
        end
        // last element, offset 4*(DEPTH-1)
        do_write(BASE + 16'(4 * (DEPTH - 1)), 32'hCAFE_F00D, 4'hF, "R2");
        do_read(BASE + 16'(4 * (DEPTH - 1)), "R2");
        // read-only contents unchanged after all writes
        for (int k = 0; k < DEPTH; k++) do_read(BASE + 16'(4 * k), "R7");
        // out of window, both edges
        do_write(BASE - 16'd4, 32'hDEAD_BEEF, 4'hF, "R8");
        do_write(BASE + 16'(4 * DEPTH), 32'hDEAD_BEEF, 4'hF, "R8");
        do_read(BASE - 16'd4, "R8");
        do_read(BASE + 16'(4 * DEPTH), "R8");
        for (int k = 0; k < DEPTH; k++) do_read(BASE + 16'(4 * k), "R8");
        // simultaneous write and read: write wins, read dropped
        rd_req = 1; rd_addr = BASE;
        do_write(BASE + 16'd8, 32'h0BAD_CAFE, 4'hF, "R9");
        rd_req = 0;
        repeat (3) begin
            @(negedge clk);
            for (int m = 0; m < 3; m++)
                chk(rd_done[m] == 1'b0, "R9", m, 32'(rd_done[m]), 32'd0);
        end
        do_read(BASE + 16'd8, "R9");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule